// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry

This block is the control state machine of a small processor. It steps through each instruction in a fixed set of phases. First it computes the next instruction address, then it fetches the word at that address into an instruction register. It then decodes the instruction and, only when needed, computes an operand address and fetches the operand. After that it runs the data operation and, only when needed, writes the result back. The datapath around it does the arithmetic and decodes the instruction bits. The sequencer receives the decoded instruction class, owns the program counter, the saved program counter and the interrupt-enable bit, and drives one memory port that uses a ready handshake.

When an instruction completes, the sequencer checks the interrupt request. If the request is raised and interrupts are enabled, it spends one cycle in an interrupt state. In that cycle it saves the program counter, loads a fixed handler address and masks further interrupts. Otherwise it goes straight to the next address phase. A return class restores the saved address and unmasks interrupts.

States and their 3-bit `state_o` codes: ADDR_CALC (0), FETCH (1), DECODE (2), OPND_ADDR (3), OPND_FETCH (4), EXECUTE (5), STORE (6), IRQ_ENTRY (7).

Transitions:
- ADDR_CALC always goes to FETCH.
- FETCH goes to DECODE on ready.
- DECODE goes to OPND_ADDR when the instruction has an operand or a store, and to EXECUTE otherwise.
- OPND_ADDR goes to OPND_FETCH when there is an operand, and to EXECUTE otherwise.
- OPND_FETCH goes to EXECUTE on ready.
- EXECUTE goes to STORE when a store is needed. Otherwise it goes to IRQ_ENTRY or ADDR_CALC.
- STORE goes to IRQ_ENTRY or ADDR_CALC on ready.
- IRQ_ENTRY goes to ADDR_CALC.

Top module: `instr_seq_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, `state_o` is 0 (ADDR_CALC), `pc_o` is RESET_ADDR (default 0), `epc_o` is 0, `ie_o` is 1 and `mem_req` is 0.
- R2: ADDR_CALC lasts one cycle and is always followed by FETCH. With no memory wait states, an instruction with neither operand nor store takes 4 cycles from one ADDR_CALC to the next.
- R3: FETCH requests a read (`mem_req`=1, `mem_we`=0) at `mem_addr`=`pc_o`. On the ready cycle it loads `mem_rdata` into `ir_o` and increments `pc_o` by one.
- R4: `dec_opnd` and `dec_store` are sampled in DECODE. OPND_ADDR runs when either is set and latches `opnd_addr`. OPND_FETCH runs only when `dec_opnd` was set, reads at the latched address and pulses `opnd_strobe` on its ready cycle. An operand instruction takes 6 cycles with no wait states.
- R5: STORE runs only when `dec_store` was set. It writes (`mem_we`=1) at the latched operand address. Operand with store takes 7 cycles; store alone takes 6.
- R6: While `mem_req` is high and `mem_ready` is low, the state and `mem_addr` hold. Each wait cycle adds one cycle to the instruction.
- R7: When `dec_jump` was set, EXECUTE loads `jump_addr` into `pc_o` in place of the incremented value.
- R8: The interrupt check happens on leaving EXECUTE (no store) or on the ready cycle of STORE. If `irq` and `ie_o` are both 1, the next state is IRQ_ENTRY (7); otherwise it is ADDR_CALC.
- R9: IRQ_ENTRY lasts one cycle. It copies `pc_o` (already updated by a jump) into `epc_o`, sets `pc_o` to HANDLER_ADDR (default 0xC0), clears `ie_o` and goes to ADDR_CALC.
- R10: While `ie_o` is 0, a high `irq` is ignored and the instruction ends in ADDR_CALC.
- R11: When `dec_rti` was set, EXECUTE loads `epc_o` into `pc_o` and sets `ie_o`. The check that ends that same instruction still uses the old, cleared enable.
- R12: `exec_strobe` is high for exactly one cycle per instruction (EXECUTE), and `opnd_strobe` pulses once per operand fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Memory address |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| irq | input | 1 | Interrupt request level |
| dec_opnd | input | 1 | Decoded: instruction reads a memory operand |
| dec_store | input | 1 | Decoded: result must be written to memory |
| dec_jump | input | 1 | Decoded: control transfer |
| dec_rti | input | 1 | Decoded: return from interrupt |
| opnd_addr | input | AW | Operand address from the datapath |
| jump_addr | input | AW | Jump target from the datapath |
| state_o | output | 3 | Current state code |
| ir_o | output | DW | Instruction register |
| pc_o | output | AW | Program counter |
| epc_o | output | AW | Saved program counter |
| ie_o | output | 1 | Interrupt enable |
| opnd_strobe | output | 1 | Operand data valid on `mem_rdata` |
| exec_strobe | output | 1 | Data operation cycle |

## Verification
On every cycle, the assertions check the local rules between states. These are the fixed step from ADDR_CALC to FETCH, the fetch increment and instruction load, holding through wait states, interrupt entry and masking, and the restore on return. Only the bench scenarios can show that whole instructions take the right number of cycles for each class. The same holds for a jump address surviving into the saved address, an interrupt being taken after a store, and a return leaving the next instruction interruptible.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [2:0] {
        ST_ADDR   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_DECODE = 3'd2,
        ST_OADDR  = 3'd3,
        ST_OFETCH = 3'd4,
        ST_EXEC   = 3'd5,
        ST_STORE  = 3'd6,
        ST_IRQ    = 3'd7
    } isc_state_e;

    typedef struct packed {
        logic opnd;
        logic store;
        logic jump;
        logic rti;
    } isc_class_t;

endpackage

// File: rtl/isc_fsm.sv
module isc_fsm
    import isc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mem_ready,
    input  logic       take_irq,
    input  isc_class_t class_in,
    output isc_state_e state,
    output isc_class_t class_q
);

    isc_state_e nxt;

    // state register and class latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_ADDR;
            class_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_DECODE) begin
                class_q <= class_in;
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_ADDR:   nxt = ST_FETCH;
            ST_FETCH:  nxt = mem_ready ? ST_DECODE : ST_FETCH;
            ST_DECODE: nxt = (class_in.opnd || class_in.store) ? ST_OADDR : ST_EXEC;
            ST_OADDR:  nxt = class_q.opnd ? ST_OFETCH : ST_EXEC;
            ST_OFETCH: nxt = mem_ready ? ST_EXEC : ST_OFETCH;
            ST_EXEC: begin
                if (class_q.store)  nxt = ST_STORE;
                else if (take_irq)  nxt = ST_IRQ;
                else                nxt = ST_ADDR;
            end
            ST_STORE: begin
                if (!mem_ready)     nxt = ST_STORE;
                else if (take_irq)  nxt = ST_IRQ;
                else                nxt = ST_ADDR;
            end
            ST_IRQ:    nxt = ST_ADDR;
        endcase
    end

    // R2
    addr_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADDR |=> state == ST_FETCH);

endmodule

// File: rtl/isc_pc_unit.sv
module isc_pc_unit
    import isc_pkg::*;
#(
    parameter int          AW           = 8,
    parameter logic [AW-1:0] RESET_ADDR   = '0,
    parameter logic [AW-1:0] HANDLER_ADDR = '0,
    parameter logic        IE_RESET     = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_enter,
    input  logic          fetch_done,
    input  logic          do_rti,
    input  logic          do_jump,
    input  logic [AW-1:0] jump_addr,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] epc,
    output logic          ie
);

    localparam logic [AW-1:0] PC_STEP = AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= RESET_ADDR;
            epc <= '0;
            ie  <= IE_RESET;
        end else if (irq_enter) begin
            epc <= pc;
            pc  <= HANDLER_ADDR;
            ie  <= 1'b0;
        end else if (fetch_done) begin
            pc <= pc + PC_STEP;
        end else if (do_rti) begin
            pc <= epc;
            ie <= 1'b1;
        end else if (do_jump) begin
            pc <= jump_addr;
        end
    end

    // R9
    irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> pc == HANDLER_ADDR && !ie && epc == $past(pc));

    // R11
    rti_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_rti && !irq_enter && !fetch_done |=> pc == $past(epc) && ie);

endmodule

// File: rtl/isc_mem_port.sv
module isc_mem_port
    import isc_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  isc_state_e    state,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] opnd_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] ir,
    output logic          opnd_strobe
);

    logic [AW-1:0] oaddr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oaddr_q <= '0;
            ir      <= '0;
        end else begin
            if (state == ST_OADDR) begin
                oaddr_q <= opnd_addr;
            end
            if (state == ST_FETCH && mem_ready) begin
                ir <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = oaddr_q;
        opnd_strobe = 1'b0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = pc;
            end
            ST_OFETCH: begin
                mem_req     = 1'b1;
                opnd_strobe = mem_ready;
            end
            ST_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_ADDR, ST_DECODE, ST_OADDR, ST_EXEC, ST_IRQ: begin
                mem_req = 1'b0;
            end
        endcase
    end

    // R6
    mem_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> state == $past(state) && mem_addr == $past(mem_addr));

endmodule

// File: rtl/instr_seq_ctrl.sv
module instr_seq_ctrl
    import isc_pkg::*;
#(
    parameter int            AW           = 8,
    parameter int            DW           = 16,
    parameter logic [AW-1:0] RESET_ADDR   = '0,
    parameter logic [AW-1:0] HANDLER_ADDR = AW'(8'hC0),
    parameter logic          IE_RESET     = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    input  logic          irq,
    input  logic          dec_opnd,
    input  logic          dec_store,
    input  logic          dec_jump,
    input  logic          dec_rti,
    input  logic [AW-1:0] opnd_addr,
    input  logic [AW-1:0] jump_addr,
    output logic [2:0]    state_o,
    output logic [DW-1:0] ir_o,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] epc_o,
    output logic          ie_o,
    output logic          opnd_strobe,
    output logic          exec_strobe
);

    localparam logic [AW-1:0] PC_STEP = AW'(1);

    isc_state_e state;
    isc_class_t class_in;
    isc_class_t class_q;
    logic       take_irq;
    logic       fetch_done;

    assign class_in   = '{opnd: dec_opnd, store: dec_store, jump: dec_jump, rti: dec_rti};
    assign take_irq   = irq && ie_o;
    assign fetch_done = (state == ST_FETCH) && mem_ready;

    isc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_ready (mem_ready),
        .take_irq  (take_irq),
        .class_in  (class_in),
        .state     (state),
        .class_q   (class_q)
    );

    isc_pc_unit #(
        .AW           (AW),
        .RESET_ADDR   (RESET_ADDR),
        .HANDLER_ADDR (HANDLER_ADDR),
        .IE_RESET     (IE_RESET)
    ) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_enter  (state == ST_IRQ),
        .fetch_done (fetch_done),
        .do_rti     ((state == ST_EXEC) && class_q.rti),
        .do_jump    ((state == ST_EXEC) && class_q.jump),
        .jump_addr  (jump_addr),
        .pc         (pc_o),
        .epc        (epc_o),
        .ie         (ie_o)
    );

    isc_mem_port #(
        .AW (AW),
        .DW (DW)
    ) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .pc          (pc_o),
        .opnd_addr   (opnd_addr),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .ir          (ir_o),
        .opnd_strobe (opnd_strobe)
    );

    assign state_o     = state;
    assign exec_strobe = (state == ST_EXEC);

    // R3
    fetch_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> pc_o == $past(pc_o) + PC_STEP && ir_o == $past(mem_rdata));

    // R8
    irq_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EXEC && !class_q.store && irq && ie_o |=> state == ST_IRQ);

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_o |=> state != ST_IRQ);

    // R9
    irq_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IRQ |=> state == ST_ADDR);

endmodule

// File: tb/instr_seq_ctrl_test.sv
module instr_seq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] ins;
        logic        irq;
        logic [7:0]  cyc;
        logic [7:0]  pc;
        logic [7:0]  epc;
        logic        ie;
        logic        wr;
    } vec_t;

    // encoding used by this bench: [15] operand, [14] store, [13] jump, [12] return, [7:0] address
    localparam vec_t VEC [14] = '{
        '{16'h0000, 1'b0, 8'd4, 8'h01, 8'h00, 1'b1, 1'b0},  // R2 plain
        '{16'h8010, 1'b0, 8'd6, 8'h02, 8'h00, 1'b1, 1'b0},  // R4 operand
        '{16'hC011, 1'b0, 8'd7, 8'h03, 8'h00, 1'b1, 1'b1},  // R5 operand+store
        '{16'h4012, 1'b0, 8'd6, 8'h04, 8'h00, 1'b1, 1'b1},  // R5 store only
        '{16'h2040, 1'b0, 8'd4, 8'h40, 8'h00, 1'b1, 1'b0},  // R7 jump
        '{16'h0000, 1'b1, 8'd5, 8'hC0, 8'h41, 1'b0, 1'b0},  // R9 taken
        '{16'h0000, 1'b1, 8'd4, 8'hC1, 8'h41, 1'b0, 1'b0},  // R10 masked
        '{16'h1000, 1'b1, 8'd4, 8'h41, 8'h41, 1'b1, 1'b0},  // R11 return, old enable
        '{16'h0000, 1'b1, 8'd5, 8'hC0, 8'h42, 1'b0, 1'b0},  // R8 taken again
        '{16'h1000, 1'b0, 8'd4, 8'h42, 8'h42, 1'b1, 1'b0},  // R11
        '{16'h2080, 1'b1, 8'd5, 8'hC0, 8'h80, 1'b0, 1'b0},  // R9 jump target saved
        '{16'h1000, 1'b0, 8'd4, 8'h80, 8'h80, 1'b1, 1'b0},  // R11
        '{16'hC020, 1'b1, 8'd8, 8'hC0, 8'h81, 1'b0, 1'b1},  // R8 after store
        '{16'h1000, 1'b0, 8'd4, 8'h81, 8'h81, 1'b1, 1'b0}   // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, mem_ready;
    logic [7:0]  mem_addr;
    logic [15:0] mem_rdata;
    logic        irq = 1'b0;
    logic [2:0]  state_o;
    logic [15:0] ir_o;
    logic [7:0]  pc_o, epc_o;
    logic        ie_o, opnd_strobe, exec_strobe;
    logic [15:0] mem [256];
    int          nwait = 0;
    int          wcnt = 0;
    int          wr_cnt = 0;
    logic [7:0]  wr_addr = '0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    assign mem_ready = mem_req && (wcnt == nwait);

    always @(posedge clk) begin
        if (mem_req && !mem_ready) wcnt <= wcnt + 1;
        else                       wcnt <= 0;
        if (mem_req && mem_we && mem_ready) begin
            wr_cnt  <= wr_cnt + 1;
            wr_addr <= mem_addr;
        end
    end

    instr_seq_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .irq         (irq),
        .dec_opnd    (ir_o[15]),
        .dec_store   (ir_o[14]),
        .dec_jump    (ir_o[13]),
        .dec_rti     (ir_o[12]),
        .opnd_addr   (ir_o[7:0]),
        .jump_addr   (ir_o[7:0]),
        .state_o     (state_o),
        .ir_o        (ir_o),
        .pc_o        (pc_o),
        .epc_o       (epc_o),
        .ie_o        (ie_o),
        .opnd_strobe (opnd_strobe),
        .exec_strobe (exec_strobe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_reset(input string req);
        chk(req, state_o, 0);
        chk(req, pc_o, 0);
        chk(req, epc_o, 0);
        chk(req, ie_o, 1);
        chk(req, mem_req, 0);
    endtask

    // runs one instruction from ADDR_CALC to the next ADDR_CALC, sampled at falling edges
    task automatic run_instr(input logic [15:0] ins, input logic irq_v,
                             output int cyc, output int n_exec, output int n_opnd);
        mem[pc_o] = ins;
        irq = irq_v;
        cyc = 0; n_exec = 0; n_opnd = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (exec_strobe) n_exec++;
            if (opnd_strobe) n_opnd++;
        end while (state_o != 3'd0 && cyc < 100);
    endtask

    initial begin
        int cyc, n_exec, n_opnd, w0;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        chk_reset("R1 held");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 fetch follows", state_o, 1);
        chk("R3 fetch addr", mem_addr, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_reset("R1 released");

        for (int v = 0; v < 14; v++) begin
            w0 = wr_cnt;
            run_instr(VEC[v].ins, VEC[v].irq, cyc, n_exec, n_opnd);
            chk($sformatf("R8 cycles v%0d", v), cyc, VEC[v].cyc);
            chk($sformatf("R7 pc v%0d", v), pc_o, VEC[v].pc);
            chk($sformatf("R9 epc v%0d", v), epc_o, VEC[v].epc);
            chk($sformatf("R10 ie v%0d", v), ie_o, VEC[v].ie);
            chk($sformatf("R5 writes v%0d", v), wr_cnt - w0, VEC[v].wr);
            if (VEC[v].wr) chk($sformatf("R5 wr addr v%0d", v), wr_addr, VEC[v].ins[7:0]);
            chk($sformatf("R3 ir v%0d", v), ir_o, VEC[v].ins);
            chk($sformatf("R12 exec v%0d", v), n_exec, 1);
            chk($sformatf("R4 opnd v%0d", v), n_opnd, VEC[v].ins[15]);
        end

        // R6: two wait states on every access
        nwait = 2;
        irq = 1'b0;
        mem[pc_o] = 16'hC030;
        w0 = wr_cnt;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 2) begin
                chk("R6 fetch stall state", state_o, 1);
                chk("R6 fetch stall addr", mem_addr, 8'h81);
                chk("R6 fetch stall ready", mem_ready, 0);
            end
            if (state_o == 3'd6) begin
                chk("R5 store we", mem_we, 1);
                chk("R5 store addr", mem_addr, 8'h30);
            end
        end while (state_o != 3'd0 && cyc < 100);
        chk("R6 cycles with waits", cyc, 13);
        chk("R6 pc", pc_o, 8'h82);
        chk("R6 write once", wr_cnt - w0, 1);

        // R1: reset in the middle of an instruction
        nwait = 0;
        mem[pc_o] = 16'h8005;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset("R1 mid-run");
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule